// File: doc/BRIEF.md
# CPU Operating-Point Stepping Sequencer

This block moves the processor clock from its present operating point to a requested one. Each operating point is an entry in a small read-only table, given as a parameter. An entry holds a frequency, a clock source, a supply level and two links that name a neighbouring entry further down and further up. The source is one of three PLLs or the crystal. When the frequency gap to the target is larger than a set maximum, the block does not jump in one move. It hops through the linked entries and waits a fixed settle time after each clock switch.

Around the hops, the block orders its side effects so that the processor is never under-supplied. It enables the PLLs it needs before using them and raises the supply before the first switch. It disables the PLLs it no longer needs and lowers the supply only after the last switch. A reduced mode for entering power collapse changes the clock only. This mode moves to a lower point that stays on the present PLL or on the crystal, and it never touches PLLs or the supply.

Each PLL, supply or clock-switch action is a request held until a one-cycle acknowledge. PLL and supply acknowledges carry a success bit.

Top module: `opstep_seq`

## Requirements
- R1: After reset, `cur_idx` is the reset entry (0), and `busy`, `done`, `err`, `pll_req`, `vdd_req` and `sw_req` are all low.
- R2: A request whose target equals `cur_idx` raises `done` one cycle after it is accepted. It issues no handshake and leaves `err` low.
- R3: When the gap between the current and target frequencies is at most MAX_DELTA_KHZ (default 256000), the next hop is the target. Otherwise the next hop is the current entry's up link when the target frequency is higher, and its down link when it is lower. The default table, given as index: kHz/source/level/down/up, is 0: 19200/crystal/0/-1/4, 1: 120000/0/2/0/4, 2: 130000/1/2/0/-1, 3: 180000/2/2/0/5, 4: 240000/0/3/0/5, 5: 350000/2/4/3/7, 6: 390000/1/5/2/-1, 7: 530000/2/7/5/-1. Crystal is source code 3.
- R4: When the link a hop needs is negative, the sequence stops with `err` high and `done` raised. `cur_idx` keeps the last entry reached.
- R5: In normal mode, before the first switch, the block first enables the target's PLL (`pll_on`=1, `pll_sel`=source). It does this only if that source differs from the start source and is not the crystal. It then raises `vdd_level` to the target level if the target level is higher than the start level.
- R6: Each hop in normal mode first enables the hop entry's PLL if it is not already marked enabled. The block then issues `sw_req` with `sw_idx` = hop entry. After `sw_ack` it raises no request for SETTLE_CYCLES (default 4) cycles.
- R7: In normal mode, after the target is reached, the block disables every marked PLL except the target's, in ascending order (`pll_on`=0). It then lowers the supply to the target level if that level is below the start level.
- R8: In collapse mode with a lower target frequency, the target becomes the highest entry at or below the requested index whose source is the crystal or the current source. In collapse mode the block raises neither `pll_req` nor `vdd_req`.
- R9: The crystal source never enters the enabled-PLL mark. It is never requested on or off.
- R10: A PLL or supply acknowledge with its success bit low ends the sequence at once with `err` high and `done` raised.
- R11: `cur_idx` changes only on the cycle after a clock-switch handshake completes, and takes that switch's `sw_idx`.
- R12: At most one of `pll_req`, `vdd_req` and `sw_req` is high at a time. A raised request and its command fields hold steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a move; taken only while not busy |
| req_target | input | IDX_W | Requested table entry |
| req_collapse | input | 1 | Power-collapse mode for this move |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a move |
| err | output | 1 | Last move ended in error; cleared by the next request |
| cur_idx | output | IDX_W | Entry the clock currently runs from |
| pll_req | output | 1 | PLL request |
| pll_on | output | 1 | 1 enable, 0 disable |
| pll_sel | output | 2 | PLL number 0..2 |
| pll_ack | input | 1 | PLL acknowledge pulse |
| pll_ok | input | 1 | PLL request succeeded |
| vdd_req | output | 1 | Supply change request |
| vdd_level | output | 3 | Requested supply level |
| vdd_ack | input | 1 | Supply acknowledge pulse |
| vdd_ok | input | 1 | Supply change succeeded |
| sw_req | output | 1 | Clock switch request |
| sw_idx | output | IDX_W | Entry to switch to |
| sw_ack | input | 1 | Clock switch complete pulse |

## Verification
The assertions check, on every cycle, the handshake rules, the settle gap after each switch, the silence of the PLL and supply lines in collapse mode, and the link between `cur_idx` and completed switches. Only the bench's scenarios can show that the right handshakes happen in the right order: which PLLs come on and go off, when the supply rises or falls, and which entries a multi-hop path visits. This includes the path that ends on a missing link, the collapse-mode substitution, and the aborts on a refused acknowledge.

// File: rtl/opstep_pkg.sv
package opstep_pkg;

    localparam int FREQ_W   = 20;
    localparam int LVL_W    = 3;
    localparam int LINK_W   = 4;
    localparam int PLL_W    = 2;
    localparam int NUM_PLLS = 3;
    localparam int MAX_OPS  = 8;

    localparam logic [PLL_W-1:0] SRC_XTAL = 2'd3;

    typedef struct packed {
        logic [FREQ_W-1:0]        khz;
        logic [PLL_W-1:0]         src;
        logic [LVL_W-1:0]         lvl;
        logic signed [LINK_W-1:0] dn;
        logic signed [LINK_W-1:0] up;
    } op_entry_t;

    typedef op_entry_t [MAX_OPS-1:0] op_table_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE_PLL, ST_PRE_VDD, ST_HOP, ST_HOP_PLL, ST_SWITCH,
        ST_SETTLE, ST_OFF_SCAN, ST_OFF_PLL, ST_POST_VDD, ST_FINISH
    } seq_state_e;

    function automatic op_entry_t mk(int khz, int src, int lvl, int dn, int up);
        op_entry_t e;
        e.khz = FREQ_W'(khz);
        e.src = PLL_W'(src);
        e.lvl = LVL_W'(lvl);
        e.dn  = LINK_W'(dn);
        e.up  = LINK_W'(up);
        return e;
    endfunction

    // Entries sorted by rising frequency; links pick intermediate hops.
    function automatic op_table_t default_ops();
        op_table_t t;
        t[0] = mk(19200,  3, 0, -1,  4);
        t[1] = mk(120000, 0, 2,  0,  4);
        t[2] = mk(130000, 1, 2,  0, -1);
        t[3] = mk(180000, 2, 2,  0,  5);
        t[4] = mk(240000, 0, 3,  0,  5);
        t[5] = mk(350000, 2, 4,  3,  7);
        t[6] = mk(390000, 1, 5,  2, -1);
        t[7] = mk(530000, 2, 7,  5, -1);
        return t;
    endfunction

endpackage

// File: rtl/opstep_hop.sv
module opstep_hop
    import opstep_pkg::*;
#(
    parameter int        NUM_OPS       = 8,
    parameter op_table_t OP_TABLE      = default_ops(),
    parameter int        MAX_DELTA_KHZ = 256000
) (
    input  logic [$clog2(NUM_OPS)-1:0] cur_idx,
    input  logic [$clog2(NUM_OPS)-1:0] tgt_idx,
    output logic [$clog2(NUM_OPS)-1:0] nxt_idx,
    output logic                       bad_link
);
    localparam int IDX_W = $clog2(NUM_OPS);
    localparam logic [FREQ_W-1:0] DELTA = FREQ_W'(MAX_DELTA_KHZ);

    op_entry_t                c_e, t_e;
    logic [FREQ_W-1:0]        gap;
    logic signed [LINK_W-1:0] link;

    always_comb begin
        c_e  = OP_TABLE[cur_idx];
        t_e  = OP_TABLE[tgt_idx];
        gap  = (c_e.khz > t_e.khz) ? (c_e.khz - t_e.khz) : (t_e.khz - c_e.khz);
        link = (t_e.khz > c_e.khz) ? c_e.up : c_e.dn;
        if (gap <= DELTA) begin
            nxt_idx  = tgt_idx;
            bad_link = 1'b0;
        end else begin
            nxt_idx  = link[IDX_W-1:0];
            bad_link = link[LINK_W-1];
        end
    end
endmodule

// File: rtl/opstep_park.sv
module opstep_park
    import opstep_pkg::*;
#(
    parameter int        NUM_OPS  = 8,
    parameter op_table_t OP_TABLE = default_ops()
) (
    input  logic [$clog2(NUM_OPS)-1:0] cur_idx,
    input  logic [$clog2(NUM_OPS)-1:0] req_idx,
    input  logic                       collapse,
    output logic [$clog2(NUM_OPS)-1:0] eff_idx
);
    localparam int IDX_W = $clog2(NUM_OPS);

    logic found;

    always_comb begin
        eff_idx = req_idx;
        found   = 1'b0;
        if (collapse && (OP_TABLE[req_idx].khz < OP_TABLE[cur_idx].khz)) begin
            for (int i = NUM_OPS - 1; i >= 0; i--) begin
                if (!found && (IDX_W'(i) <= req_idx) &&
                    ((OP_TABLE[i].src == SRC_XTAL) ||
                     (OP_TABLE[i].src == OP_TABLE[cur_idx].src))) begin
                    eff_idx = IDX_W'(i);
                    found   = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/opstep_seq.sv
module opstep_seq
    import opstep_pkg::*;
#(
    parameter int        NUM_OPS       = 8,
    parameter op_table_t OP_TABLE      = default_ops(),
    parameter int        MAX_DELTA_KHZ = 256000,
    parameter int        SETTLE_CYCLES = 4,
    parameter int        RESET_IDX     = 0,
    localparam int       IDX_W         = $clog2(NUM_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_target,
    input  logic             req_collapse,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [IDX_W-1:0] cur_idx,
    output logic             pll_req,
    output logic             pll_on,
    output logic [PLL_W-1:0] pll_sel,
    input  logic             pll_ack,
    input  logic             pll_ok,
    output logic             vdd_req,
    output logic [LVL_W-1:0] vdd_level,
    input  logic             vdd_ack,
    input  logic             vdd_ok,
    output logic             sw_req,
    output logic [IDX_W-1:0] sw_idx,
    input  logic             sw_ack
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        seq_state_e          st;
        logic [IDX_W-1:0]    cur;
        logic [IDX_W-1:0]    start;
        logic [IDX_W-1:0]    tgt;
        logic [IDX_W-1:0]    hop;
        logic                park;
        logic [NUM_PLLS-1:0] mask;
        logic [PLL_W-1:0]    scan;
        logic [CNT_W-1:0]    cnt;
        logic                err;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] eff_idx, nxt_idx;
    logic             bad_link;

    function automatic logic [NUM_PLLS-1:0] src_bit(logic [PLL_W-1:0] s);
        return (s == SRC_XTAL) ? '0 : (NUM_PLLS'(1) << s);
    endfunction

    function automatic logic pll_up_needed(logic [IDX_W-1:0] a, logic [IDX_W-1:0] b);
        return (OP_TABLE[b].src != SRC_XTAL) && (OP_TABLE[b].src != OP_TABLE[a].src);
    endfunction

    opstep_park #(.NUM_OPS(NUM_OPS), .OP_TABLE(OP_TABLE)) u_park (
        .cur_idx (r_q.cur),
        .req_idx (req_target),
        .collapse(req_collapse),
        .eff_idx (eff_idx)
    );

    opstep_hop #(.NUM_OPS(NUM_OPS), .OP_TABLE(OP_TABLE),
                 .MAX_DELTA_KHZ(MAX_DELTA_KHZ)) u_hop (
        .cur_idx (r_q.cur),
        .tgt_idx (r_q.tgt),
        .nxt_idx (nxt_idx),
        .bad_link(bad_link)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.err = 1'b0;
                    if (req_target == r_q.cur) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.start = r_q.cur;
                        r_d.tgt   = eff_idx;
                        r_d.park  = req_collapse;
                        r_d.mask  = src_bit(OP_TABLE[r_q.cur].src);
                        if (!req_collapse && pll_up_needed(r_q.cur, eff_idx))
                            r_d.st = ST_PRE_PLL;
                        else if (!req_collapse && (OP_TABLE[eff_idx].lvl > OP_TABLE[r_q.cur].lvl))
                            r_d.st = ST_PRE_VDD;
                        else
                            r_d.st = ST_HOP;
                    end
                end
            end
            ST_PRE_PLL: if (pll_ack) begin
                if (!pll_ok) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FINISH;
                end else begin
                    r_d.mask = r_q.mask | src_bit(OP_TABLE[r_q.tgt].src);
                    r_d.st   = (OP_TABLE[r_q.tgt].lvl > OP_TABLE[r_q.start].lvl) ? ST_PRE_VDD : ST_HOP;
                end
            end
            ST_PRE_VDD: if (vdd_ack) begin
                r_d.err = !vdd_ok;
                r_d.st  = vdd_ok ? ST_HOP : ST_FINISH;
            end
            ST_HOP: begin
                if (bad_link) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FINISH;
                end else begin
                    r_d.hop = nxt_idx;
                    if (!r_q.park && ((src_bit(OP_TABLE[nxt_idx].src) & ~r_q.mask) != '0))
                        r_d.st = ST_HOP_PLL;
                    else
                        r_d.st = ST_SWITCH;
                end
            end
            ST_HOP_PLL: if (pll_ack) begin
                if (!pll_ok) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FINISH;
                end else begin
                    r_d.mask = r_q.mask | src_bit(OP_TABLE[r_q.hop].src);
                    r_d.st   = ST_SWITCH;
                end
            end
            ST_SWITCH: if (sw_ack) begin
                r_d.cur = r_q.hop;
                r_d.cnt = CNT_W'(SETTLE_CYCLES - 1);
                r_d.st  = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.cur != r_q.tgt) begin
                    r_d.st = ST_HOP;
                end else if (r_q.park) begin
                    r_d.st = ST_FINISH;
                end else begin
                    r_d.mask = r_q.mask & ~src_bit(OP_TABLE[r_q.tgt].src);
                    r_d.scan = '0;
                    r_d.st   = ST_OFF_SCAN;
                end
            end
            ST_OFF_SCAN: begin
                if (r_q.scan == PLL_W'(NUM_PLLS))
                    r_d.st = (OP_TABLE[r_q.tgt].lvl < OP_TABLE[r_q.start].lvl) ? ST_POST_VDD : ST_FINISH;
                else if (r_q.mask[r_q.scan])
                    r_d.st = ST_OFF_PLL;
                else
                    r_d.scan = r_q.scan + 1'b1;
            end
            ST_OFF_PLL: if (pll_ack) begin
                if (!pll_ok) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FINISH;
                end else begin
                    r_d.mask[r_q.scan] = 1'b0;
                    r_d.scan           = r_q.scan + 1'b1;
                    r_d.st             = ST_OFF_SCAN;
                end
            end
            ST_POST_VDD: if (vdd_ack) begin
                r_d.err = !vdd_ok;
                r_d.st  = ST_FINISH;
            end
            ST_FINISH: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.cur <= IDX_W'(RESET_IDX);
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FINISH);
    assign err       = r_q.err;
    assign cur_idx   = r_q.cur;
    assign pll_req   = (r_q.st == ST_PRE_PLL) || (r_q.st == ST_HOP_PLL) || (r_q.st == ST_OFF_PLL);
    assign pll_on    = (r_q.st != ST_OFF_PLL);
    assign pll_sel   = (r_q.st == ST_OFF_PLL) ? r_q.scan :
                       (r_q.st == ST_HOP_PLL) ? OP_TABLE[r_q.hop].src : OP_TABLE[r_q.tgt].src;
    assign vdd_req   = (r_q.st == ST_PRE_VDD) || (r_q.st == ST_POST_VDD);
    assign vdd_level = OP_TABLE[r_q.tgt].lvl;
    assign sw_req    = (r_q.st == ST_SWITCH);
    assign sw_idx    = r_q.hop;
endmodule

// File: rtl/opstep_seq_chk.sv
module opstep_seq_chk #(
    parameter int IDX_W         = 3,
    parameter int SETTLE_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_collapse,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [IDX_W-1:0] cur_idx,
    input logic             pll_req,
    input logic             pll_on,
    input logic [1:0]       pll_sel,
    input logic             pll_ack,
    input logic             vdd_req,
    input logic             sw_req,
    input logic [IDX_W-1:0] sw_idx,
    input logic             sw_ack
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic             park_seen;
    logic [CNT_W-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_seen <= 1'b0;
            gap_cnt   <= '0;
        end else begin
            if (req_valid && !busy) park_seen <= req_collapse;
            if (sw_req && sw_ack)   gap_cnt   <= CNT_W'(SETTLE_CYCLES);
            else if (gap_cnt != '0) gap_cnt   <= gap_cnt - 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pll_req && !vdd_req && !sw_req));

    // R12
    one_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pll_req, vdd_req, sw_req}));

    // R12
    pll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> (pll_req && $stable(pll_sel) && $stable(pll_on)));

    // R12
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_ack) |=> (sw_req && $stable(sw_idx)));

    // R11
    cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_idx) |-> $past(sw_req && sw_ack));

    // R11
    cur_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_req && sw_ack) |-> (cur_idx == $past(sw_idx)));

    // R6
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt != '0) |-> (!sw_req && !pll_req && !vdd_req));

    // R8
    park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_seen && busy) |-> (!pll_req && !vdd_req));

    // R4
    err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
endmodule

bind opstep_seq opstep_seq_chk #(.IDX_W(IDX_W), .SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_collapse(req_collapse),
    .busy(busy), .done(done), .err(err), .cur_idx(cur_idx),
    .pll_req(pll_req), .pll_on(pll_on), .pll_sel(pll_sel), .pll_ack(pll_ack),
    .vdd_req(vdd_req), .sw_req(sw_req), .sw_idx(sw_idx), .sw_ack(sw_ack)
);

// File: tb/opstep_seq_test.sv
`timescale 1ns/1ps
module opstep_seq_test;
    localparam int SETTLE = 4;
    localparam int DELTA  = 256000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_target = '0;
    logic       req_collapse = 1'b0;
    logic       busy, done, err;
    logic [2:0] cur_idx;
    logic       pll_req, pll_on;
    logic [1:0] pll_sel;
    logic       pll_ack = 1'b0, pll_ok = 1'b1;
    logic       vdd_req;
    logic [2:0] vdd_level;
    logic       vdd_ack = 1'b0, vdd_ok = 1'b1;
    logic       sw_req;
    logic [2:0] sw_idx;
    logic       sw_ack = 1'b0;

    always #2 clk = ~clk;

    opstep_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_collapse(req_collapse), .busy(busy), .done(done), .err(err), .cur_idx(cur_idx),
        .pll_req(pll_req), .pll_on(pll_on), .pll_sel(pll_sel), .pll_ack(pll_ack), .pll_ok(pll_ok),
        .vdd_req(vdd_req), .vdd_level(vdd_level), .vdd_ack(vdd_ack), .vdd_ok(vdd_ok),
        .sw_req(sw_req), .sw_idx(sw_idx), .sw_ack(sw_ack)
    );

    // Reference table (R3): kHz, source (3 = crystal), level, down, up.
    int tk[8]  = '{19200, 120000, 130000, 180000, 240000, 350000, 390000, 530000};
    int ts[8]  = '{3, 0, 1, 2, 0, 2, 1, 2};
    int tl[8]  = '{0, 2, 2, 2, 3, 4, 5, 7};
    int tdn[8] = '{-1, 0, 0, 0, 0, 3, 2, 5};
    int tup[8] = '{4, 4, -1, 5, 5, 7, -1, -1};

    // Responder state (written only by the responder process).
    int got_q[$];
    int hs_count = 0;
    int model_cur = 0;
    int pend_val = 0;
    bit pend_cur = 0;
    int since_sw = 1000;
    int cur_checks = 0, cur_bad = 0, gap_bad = 0;

    // Stimulus state (written only by the initial block).
    int fail_abs = -1;
    int exp_q[$];
    int total = 0, bad = 0;

    always @(negedge clk) begin
        bit pa, va, sa;
        if (pend_cur) begin
            model_cur = pend_val;
            pend_cur  = 0;
        end
        if (rst_n) begin
            cur_checks++;
            if (cur_idx !== 3'(model_cur)) begin
                cur_bad++;
                $display("FAIL R11 cur_idx act=%0d exp=%0d", cur_idx, model_cur);
            end
        end
        if (since_sw < 1000) since_sw++;
        pa = pll_req && !pll_ack;
        va = vdd_req && !vdd_ack;
        sa = sw_req && !sw_ack;
        pll_ack = pa; vdd_ack = va; sw_ack = sa;
        pll_ok = 1'b1; vdd_ok = 1'b1;
        if (pa || va || sa) begin
            cur_checks++;
            if (since_sw < SETTLE + 2) begin
                gap_bad++;
                $display("FAIL R6 settle gap act=%0d exp>=%0d", since_sw, SETTLE + 2);
            end
        end
        if (pa) begin
            got_q.push_back((pll_on ? 100 : 200) + int'(pll_sel));
            pll_ok = (hs_count != fail_abs);
            hs_count++;
        end
        if (va) begin
            got_q.push_back(300 + int'(vdd_level));
            vdd_ok = (hs_count != fail_abs);
            hs_count++;
        end
        if (sa) begin
            got_q.push_back(400 + int'(sw_idx));
            pend_cur = 1; pend_val = int'(sw_idx);
            since_sw = 0;
            hs_count++;
        end
    end

    task automatic chk(bit ok, string rq, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    // Behavioural expectation: list of handshakes, final error and final entry.
    task automatic plan(int start, int tgt_in, bit park, int fail_k, output bit eerr, output int ecur);
        int tgt, c, n, m, lnk, d;
        exp_q.delete();
        eerr = 0; ecur = start; tgt = tgt_in;
        if (tgt == start) return;
        if (park && tk[tgt] < tk[start])
            for (int j = tgt; j >= 0; j--)
                if (ts[j] == 3 || ts[j] == ts[start]) begin tgt = j; break; end
        m = (ts[start] != 3) ? (1 << ts[start]) : 0;
        if (!park) begin
            if (ts[tgt] != ts[start] && ts[tgt] != 3) begin exp_q.push_back(100 + ts[tgt]); m |= 1 << ts[tgt]; end
            if (tl[tgt] > tl[start]) exp_q.push_back(300 + tl[tgt]);
        end
        c = start;
        while (c != tgt && !eerr) begin
            d = tk[c] > tk[tgt] ? tk[c] - tk[tgt] : tk[tgt] - tk[c];
            if (d <= DELTA) n = tgt;
            else begin
                lnk = tk[tgt] > tk[c] ? tup[c] : tdn[c];
                if (lnk < 0) eerr = 1;
                n = lnk;
            end
            if (!eerr) begin
                if (!park && ts[n] != 3 && ((m >> ts[n]) & 1) == 0) begin exp_q.push_back(100 + ts[n]); m |= 1 << ts[n]; end
                exp_q.push_back(400 + n);
                c = n;
            end
        end
        if (!eerr && !park) begin
            if (ts[tgt] != 3) m &= ~(1 << ts[tgt]);
            for (int p = 0; p < 3; p++) if ((m >> p) & 1) exp_q.push_back(200 + p);
            if (tl[tgt] < tl[start]) exp_q.push_back(300 + tl[tgt]);
        end
        if (fail_k >= 0) begin
            while (exp_q.size() > fail_k + 1) void'(exp_q.pop_back());
            eerr = 1;
        end
        ecur = start;
        foreach (exp_q[i]) if (exp_q[i] >= 400) ecur = exp_q[i] - 400;
        if (fail_k < 0 && !eerr) ecur = tgt;
    endtask

    task automatic run(int tgt, bit park, int fail_k, string rq);
        bit eerr; int ecur, base, guard;
        plan(model_cur, tgt, park, fail_k, eerr, ecur);
        base = got_q.size();
        fail_abs = (fail_k >= 0) ? hs_count + fail_k : -1;
        @(negedge clk);
        req_valid = 1'b1; req_target = 3'(tgt); req_collapse = park;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 3000) begin @(negedge clk); guard++; end
        chk(done, {rq, " done"}, done, 1);
        if (tgt == int'(cur_idx) && !busy && exp_q.size() == 0 && fail_k < 0 && guard == 0)
            chk(1'b1, {rq, " quick"}, guard, 0);
        chk(got_q.size() - base == exp_q.size(), {rq, " handshake count"}, got_q.size() - base, exp_q.size());
        for (int i = 0; i < exp_q.size() && base + i < got_q.size(); i++)
            chk(got_q[base + i] == exp_q[i], {rq, " handshake"}, got_q[base + i], exp_q[i]);
        chk(err == eerr, {rq, " err"}, err, eerr);
        chk(int'(cur_idx) == ecur, {rq, " cur_idx"}, cur_idx, ecur);
        @(negedge clk);
        chk(!busy, {rq, " idle"}, busy, 0);
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total + cur_checks + 1, bad + cur_bad + gap_bad + 1);
        $finish;
    end

    initial begin
        int g;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cur_idx == 3'd0, "R1 cur_idx", cur_idx, 0);
        chk(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
        chk(!pll_req && !vdd_req && !sw_req, "R1 requests", {pll_req, vdd_req, sw_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(7, 0, -1, "R3 R5 R6 R7 R9 multi-hop up");
        // R2 same target: done on the first sampled cycle
        @(negedge clk);
        req_valid = 1'b1; req_target = 3'd7; req_collapse = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done, "R2 immediate done", done, 1);
        g = got_q.size();
        repeat (3) @(negedge clk);
        chk(got_q.size() == g && !err, "R2 no handshake", got_q.size() - g, 0);
        run(1, 0, -1, "R3 R7 down with supply drop");
        run(2, 0, -1, "R3 direct jump");
        run(7, 0, -1, "R4 negative link");
        run(5, 1, -1, "R8 collapse upward");
        run(1, 1, -1, "R8 collapse substitution");
        run(4, 0, 0,  "R10 pll refused");
        run(3, 0, -1, "R5 R9 from crystal");
        run(7, 0, 0,  "R10 supply refused");
        run(0, 0, -1, "R7 R9 back to crystal");
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total + cur_checks, bad + cur_bad + gap_bad);
        $finish;
    end
endmodule